// File: doc/BRIEF.md
# ADB Host Transaction Sequencer

This block runs one desktop-bus transaction at a time on the host side of an external bus transceiver. The link to the transceiver is a byte shifter. The block loads outgoing bytes into the shifter, and the shifter returns a one-cycle done pulse, together with the received byte, after each byte has moved. The block also drives a two-bit phase code. The transceiver advances by one byte each time that code changes.

Sampled at fixed phases, the transceiver's active-low controller flag tells the sequencer four things:
- a buffered autopoll packet is waiting;
- a device did not answer (bus timeout);
- another device wants service (SRQ);
- the current packet has ended.

A request is one command byte plus optional data bytes, a byte count and a reply-expected flag. The block reports each request with a done pulse and an error flag. Packets that no request asked for are reported with a packet pulse. Both kinds share a registered reply buffer and a reply-length output.

Top module: `adb_host_seq`

## Requirements
- R1: After reset, phase_o is IDLE (2'b11) and sh_out_o is 0 (shifter set to input). While phase_o is IDLE the shifter stays in input mode.
- R2: A request is accepted when req_valid_i is high, req_ready_o is high and sh_done_i is low. In the next cycle the command byte is on sh_data_o with sh_load_o high, sh_out_o high and phase_o CMD (2'b00). Each later shift-done with the flag high loads the next data byte, in order. After the last byte of a request with no reply and a non-Talk command, done_o pulses with err_o low, and the phase returns to IDLE.
- R3: Phase codes are CMD=00, EVEN=01, ODD=10 and IDLE=11. After the command byte the phase becomes EVEN. Each later byte inverts both bits.
- R4: When a reply is expected, the sequencer does the following once the request is sent:
  - it switches the shifter to input;
  - it stores the command byte as reply byte 0;
  - it appends each received byte while the flag is high.
  A low flag that is not a timeout or SRQ mark ends the packet: that byte is dropped, done_o pulses and reply_len_o gives the stored count.
- R5: A shift-done in IDLE with the flag low starts an autopoll packet. The received byte becomes reply byte 0 and the phase goes to EVEN. The packet ends with pkt_o. A shift-done in IDLE with the flag high is ignored: no pulse and no phase change.
- R6: A low flag on the shift-done of a command byte starts a packet read. Reply byte 0 is the most recently sent Talk command, and the shifter switches to input. When that packet ends with pkt_o, the pending request is restarted from its command byte.
- R7: While reading, a low flag at EVEN with exactly one byte stored sets timeout_o. Reading continues, and the packet is reported with reply_len_o equal to 0.
- R8: While reading, a low flag at ODD with exactly two bytes stored sets srq_o. That byte is stored and reading continues.
- R9: The reply buffer holds at most 16 bytes. Further received bytes are dropped, and reply_len_o never exceeds 16.
- R10: A request whose byte count (command byte included) is 0 or greater than 14 is rejected. The next cycle has done_o and err_o high, no shifter load, and the phase left at IDLE.
- R11: A command is a Talk when bits [3:2] are 11. A Talk request with no reply expected pulses done_o as soon as it has been sent. Its answer is then read into the buffer with the command as byte 0 and reported with pkt_o.
- R12: last_poll_o takes the value of a command that is sent with the flag high after its command byte and whose bits [3:0] are 1100 (Talk register 0). Other Talk commands leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| req_cmd_i | input | 8 | Command byte |
| req_data_i | input | 104 | Data bytes; byte k (from 1) in bits [(k-1)*8 +: 8] |
| req_len_i | input | 4 | Byte count including the command byte |
| req_reply_i | input | 1 | Reply expected |
| done_o | output | 1 | Request finished (one cycle) |
| err_o | output | 1 | Request rejected, valid with done_o |
| pkt_o | output | 1 | Unrequested packet finished (one cycle) |
| timeout_o | output | 1 | Bus timeout seen in the reported packet |
| srq_o | output | 1 | Service request seen in the reported packet |
| reply_len_o | output | 5 | Reported reply length |
| reply_data_o | output | 128 | Reply buffer; byte k in bits [k*8 +: 8] |
| last_poll_o | output | 8 | Last Talk register 0 command sent |
| phase_o | output | 2 | Transaction phase code to the transceiver |
| sh_load_o | output | 1 | Load sh_data_o into the shifter |
| sh_data_o | output | 8 | Byte to shift out |
| sh_out_o | output | 1 | Shifter direction, 1 = output |
| sh_done_i | input | 1 | Shifter finished a byte (one cycle) |
| sh_rx_i | input | 8 | Byte received by the shifter |
| ctlr_n_i | input | 1 | Controller flag, active low |

## Verification
The checker assumes the following about the inputs:
- sh_done_i arrives as single-cycle pulses, each sent in answer to a phase change or a load;
- ctlr_n_i and sh_rx_i are valid in the cycle of that pulse;
- a request strobe never coincides with a shift-done.

The bench keeps to these assumptions. Its tasks apply one event at a time on the falling clock edge, and each read sequence is completed before the next request is sent. Under these conditions the command phase can only lead to EVEN or IDLE, a rejection never leaves IDLE, and a timeout always reports zero length.

// File: rtl/adb_seq_pkg.sv
package adb_seq_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'b00,
    PH_EVEN = 2'b01,
    PH_ODD  = 2'b10,
    PH_IDLE = 2'b11
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_READ
  } seq_st_e;

  function automatic logic is_talk(input logic [7:0] c);
    return c[3:2] == 2'b11;
  endfunction

  function automatic logic is_poll(input logic [7:0] c);
    return c[3:0] == 4'b1100;
  endfunction

  // command byte goes to EVEN, every later byte flips both bits
  function automatic phase_e step_phase(input phase_e p);
    return (p == PH_CMD) ? PH_EVEN : phase_e'(~p);
  endfunction
endpackage

// File: rtl/adb_req_store.sv
module adb_req_store #(
  parameter int MAX_BYTES = 14,
  parameter int LW        = $clog2(MAX_BYTES + 2),
  parameter int DW        = (MAX_BYTES - 1) * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [7:0]    cmd_i,
  input  logic [DW-1:0] data_i,
  input  logic [LW-1:0] len_i,
  input  logic          reply_i,
  input  logic [LW-1:0] idx_i,
  output logic [7:0]    cmd_o,
  output logic [LW-1:0] len_o,
  output logic          reply_o,
  output logic [7:0]    byte_o
);
  logic [7:0] byte_q [MAX_BYTES];

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    if (g == 0) begin : g_cmd
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)    byte_q[g] <= '0;
        else if (cap_i) byte_q[g] <= cmd_i;
    end else begin : g_dat
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)    byte_q[g] <= '0;
        else if (cap_i) byte_q[g] <= data_i[(g-1)*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o   <= '0;
      reply_o <= 1'b0;
    end else if (cap_i) begin
      len_o   <= len_i;
      reply_o <= reply_i;
    end
  end

  assign cmd_o = byte_q[0];

  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < MAX_BYTES; i++)
      if (idx_i == LW'(i)) byte_o = byte_q[i];
  end
endmodule

// File: rtl/adb_reply_buf.sv
module adb_reply_buf #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               push_i,
  input  logic [7:0]         byte_i,
  output logic [CW-1:0]      cnt_o,
  output logic [DEPTH*8-1:0] data_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (start_i)                          cnt_q <= CW'(1);
    else if (push_i && cnt_q < CW'(DEPTH))     cnt_q <= cnt_q + CW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [7:0] ent_q;
    logic       wr;
    if (g == 0) begin : g_first
      assign wr = start_i;
    end else begin : g_rest
      assign wr = push_i && !start_i && (cnt_q == CW'(g));
    end
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)  ent_q <= '0;
      else if (wr)  ent_q <= byte_i;
    assign data_o[g*8 +: 8] = ent_q;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/adb_host_seq.sv
module adb_host_seq
  import adb_seq_pkg::*;
#(
  parameter int MAX_BYTES   = 14,
  parameter int REPLY_DEPTH = 16,
  localparam int LW = $clog2(MAX_BYTES + 2),
  localparam int CW = $clog2(REPLY_DEPTH + 1),
  localparam int DW = (MAX_BYTES - 1) * 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [7:0]               req_cmd_i,
  input  logic [DW-1:0]            req_data_i,
  input  logic [LW-1:0]            req_len_i,
  input  logic                     req_reply_i,
  output logic                     done_o,
  output logic                     err_o,
  output logic                     pkt_o,
  output logic                     timeout_o,
  output logic                     srq_o,
  output logic [CW-1:0]            reply_len_o,
  output logic [REPLY_DEPTH*8-1:0] reply_data_o,
  output logic [7:0]               last_poll_o,
  output logic [1:0]               phase_o,
  output logic                     sh_load_o,
  output logic [7:0]               sh_data_o,
  output logic                     sh_out_o,
  input  logic                     sh_done_i,
  input  logic [7:0]               sh_rx_i,
  input  logic                     ctlr_n_i
);
  seq_st_e       st_q, st_d;
  phase_e        ph_q, ph_d;
  logic          dir_q, dir_d, ld_q, ld_d, pend_q, pend_d, rr_q, rr_d;
  logic          to_q, to_d, srq_q, srq_d;
  logic          done_q, done_d, err_q, err_d, pkt_q, pkt_d;
  logic [LW-1:0] idx_q, idx_d;
  logic [7:0]    ldat_q, ldat_d, talk_q, talk_d, poll_q, poll_d;
  logic [CW-1:0] rlen_q, rlen_d;

  logic          cap, rb_start, rb_push, go_idle, go_send, accept, len_ok;
  logic [7:0]    rb_byte, send_cmd, s_cmd, s_byte;
  logic [LW-1:0] s_len;
  logic          s_reply;
  logic [CW-1:0] rb_cnt;

  adb_req_store #(.MAX_BYTES(MAX_BYTES), .LW(LW), .DW(DW)) i_store (
    .clk_i, .rst_ni,
    .cap_i   (cap),
    .cmd_i   (req_cmd_i),
    .data_i  (req_data_i),
    .len_i   (req_len_i),
    .reply_i (req_reply_i),
    .idx_i   (idx_q),
    .cmd_o   (s_cmd),
    .len_o   (s_len),
    .reply_o (s_reply),
    .byte_o  (s_byte)
  );

  adb_reply_buf #(.DEPTH(REPLY_DEPTH), .CW(CW)) i_rbuf (
    .clk_i, .rst_ni,
    .start_i (rb_start),
    .push_i  (rb_push),
    .byte_i  (rb_byte),
    .cnt_o   (rb_cnt),
    .data_o  (reply_data_o)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o && !sh_done_i;
  assign len_ok      = (req_len_i != '0) && (req_len_i <= LW'(MAX_BYTES));

  always_comb begin
    st_d = st_q;  ph_d = ph_q;  dir_d = dir_q;  idx_d = idx_q;
    ld_d = 1'b0;  ldat_d = ldat_q;  pend_d = pend_q;  rr_d = rr_q;
    to_d = to_q;  srq_d = srq_q;  rlen_d = rlen_q;
    done_d = 1'b0;  err_d = 1'b0;  pkt_d = 1'b0;
    talk_d = talk_q;  poll_d = poll_q;
    cap = 1'b0;  rb_start = 1'b0;  rb_push = 1'b0;  rb_byte = sh_rx_i;
    go_idle = 1'b0;  go_send = 1'b0;  send_cmd = s_cmd;

    unique case (st_q)
      ST_IDLE: begin
        if (sh_done_i) begin
          if (!ctlr_n_i) begin            // buffered autopoll data waiting
            rb_start = 1'b1;
            rr_d  = 1'b0;  to_d = 1'b0;  srq_d = 1'b0;
            st_d  = ST_READ;
            ph_d  = PH_EVEN;
          end
        end else if (accept) begin
          if (len_ok) begin
            cap = 1'b1;  go_send = 1'b1;  send_cmd = req_cmd_i;
            to_d = 1'b0;  srq_d = 1'b0;
          end else begin
            done_d = 1'b1;  err_d = 1'b1;  rlen_d = '0;
          end
        end
      end

      ST_SEND: begin
        if (sh_done_i) begin
          if (ph_q == PH_CMD && ctlr_n_i && is_talk(s_cmd)) begin
            talk_d = s_cmd;
            if (is_poll(s_cmd)) poll_d = s_cmd;
          end
          if (ph_q == PH_CMD && !ctlr_n_i) begin
            // first byte of the buffered reply was lost on the output shift
            st_d = ST_READ;  rr_d = 1'b0;  dir_d = 1'b0;
            rb_start = 1'b1;  rb_byte = talk_q;
            to_d = 1'b0;  srq_d = 1'b0;
            ph_d = step_phase(ph_q);
          end else if (idx_q >= s_len) begin
            if (s_reply || is_talk(s_cmd)) begin
              st_d = ST_READ;  rr_d = s_reply;  dir_d = 1'b0;
              rb_start = 1'b1;  rb_byte = s_cmd;
              to_d = 1'b0;  srq_d = 1'b0;
              ph_d = step_phase(ph_q);
              if (!s_reply) begin
                done_d = 1'b1;  rlen_d = '0;  pend_d = 1'b0;
              end
            end else begin
              done_d = 1'b1;  rlen_d = '0;  pend_d = 1'b0;  go_idle = 1'b1;
            end
          end else begin
            ld_d = 1'b1;  ldat_d = s_byte;
            idx_d = idx_q + LW'(1);
            ph_d = step_phase(ph_q);
          end
        end
      end

      ST_READ: begin
        if (sh_done_i) begin
          if (!ctlr_n_i && ph_q == PH_EVEN && rb_cnt == CW'(1)) begin
            to_d = 1'b1;  rb_push = 1'b1;  ph_d = step_phase(ph_q);
          end else if (!ctlr_n_i && ph_q == PH_ODD && rb_cnt == CW'(2)) begin
            srq_d = 1'b1;  rb_push = 1'b1;  ph_d = step_phase(ph_q);
          end else if (!ctlr_n_i) begin
            rlen_d = to_q ? '0 : rb_cnt;
            if (rr_q) begin
              done_d = 1'b1;  pend_d = 1'b0;
            end else begin
              pkt_d = 1'b1;
            end
            go_idle = 1'b1;
          end else begin
            rb_push = 1'b1;  ph_d = step_phase(ph_q);
          end
        end
      end

      default: st_d = ST_IDLE;
    endcase

    if (go_idle) begin
      if (pend_d) begin
        go_send = 1'b1;  send_cmd = s_cmd;   // restart the held request
      end else begin
        st_d = ST_IDLE;  ph_d = PH_IDLE;  dir_d = 1'b0;
      end
    end
    if (go_send) begin
      st_d = ST_SEND;  ph_d = PH_CMD;  dir_d = 1'b1;
      ld_d = 1'b1;  ldat_d = send_cmd;  idx_d = LW'(1);  pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  ph_q <= PH_IDLE;  dir_q <= 1'b0;  idx_q <= '0;
      ld_q <= 1'b0;  ldat_q <= '0;  pend_q <= 1'b0;  rr_q <= 1'b0;
      to_q <= 1'b0;  srq_q <= 1'b0;  rlen_q <= '0;
      done_q <= 1'b0;  err_q <= 1'b0;  pkt_q <= 1'b0;
      talk_q <= '0;  poll_q <= '0;
    end else begin
      st_q <= st_d;  ph_q <= ph_d;  dir_q <= dir_d;  idx_q <= idx_d;
      ld_q <= ld_d;  ldat_q <= ldat_d;  pend_q <= pend_d;  rr_q <= rr_d;
      to_q <= to_d;  srq_q <= srq_d;  rlen_q <= rlen_d;
      done_q <= done_d;  err_q <= err_d;  pkt_q <= pkt_d;
      talk_q <= talk_d;  poll_q <= poll_d;
    end
  end

  assign phase_o     = ph_q;
  assign sh_out_o    = dir_q;
  assign sh_load_o   = ld_q;
  assign sh_data_o   = ldat_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign pkt_o       = pkt_q;
  assign timeout_o   = to_q;
  assign srq_o       = srq_q;
  assign reply_len_o = rlen_q;
  assign last_poll_o = poll_q;
endmodule

// File: rtl/adb_host_seq_chk.sv
module adb_host_seq_chk #(
  parameter int REPLY_DEPTH = 16,
  parameter int CW          = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    phase_o,
  input logic          sh_load_o,
  input logic          sh_out_o,
  input logic          done_o,
  input logic          err_o,
  input logic          pkt_o,
  input logic          timeout_o,
  input logic [CW-1:0] reply_len_o
);
  AST_IDLE_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 2'b11 |-> !sh_out_o);                                         // R1

  AST_LOAD_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_load_o |-> sh_out_o);                                                 // R2

  AST_CMD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_o) == 2'b00 && phase_o != 2'b00) |-> (phase_o == 2'b01 || phase_o == 2'b11)); // R3

  AST_EVENT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && pkt_o));                                                     // R4

  AST_TIMEOUT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((done_o || pkt_o) && timeout_o) |-> reply_len_o == '0);                 // R7

  AST_LEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_len_o <= CW'(REPLY_DEPTH));                                        // R9

  AST_REJECT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (phase_o == 2'b11 && !sh_load_o));                 // R10
endmodule

bind adb_host_seq adb_host_seq_chk #(.REPLY_DEPTH(REPLY_DEPTH), .CW(CW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_o     (phase_o),
  .sh_load_o   (sh_load_o),
  .sh_out_o    (sh_out_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .pkt_o       (pkt_o),
  .timeout_o   (timeout_o),
  .reply_len_o (reply_len_o)
);

// File: tb/test_adb_host_seq.sv
module test_adb_host_seq;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [7:0]   req_cmd_i = '0;
  logic [103:0] req_data_i = '0;
  logic [3:0]   req_len_i = '0;
  logic         req_reply_i = 1'b0;
  logic         done_o, err_o, pkt_o, timeout_o, srq_o;
  logic [4:0]   reply_len_o;
  logic [127:0] reply_data_o;
  logic [7:0]   last_poll_o;
  logic [1:0]   phase_o;
  logic         sh_load_o;
  logic [7:0]   sh_data_o;
  logic         sh_out_o;
  logic         sh_done_i = 1'b0;
  logic [7:0]   sh_rx_i = '0;
  logic         ctlr_n_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #10 clk_i = ~clk_i;

  adb_host_seq i_adb_host_seq (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rb(input int k);
    return reply_data_o[k*8 +: 8];
  endfunction

  // all tasks start and end just after a falling edge
  task automatic send_req(input logic [7:0] cmd, input logic [3:0] len,
                          input logic [103:0] data, input logic rep);
    chk("R2 ready", req_ready_o, 1);
    req_valid_i = 1'b1; req_cmd_i = cmd; req_len_i = len;
    req_data_i = data; req_reply_i = rep;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic shift(input logic fl_n, input logic [7:0] rx);
    sh_done_i = 1'b1; ctlr_n_i = fl_n; sh_rx_i = rx;
    @(negedge clk_i);
    sh_done_i = 1'b0; ctlr_n_i = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 phase", phase_o, 2'b11);
    chk("R1 dir", sh_out_o, 0);
    chk("R1 done", done_o, 0);
  endtask

  task automatic t_write;   // R2 R3
    send_req(8'h2B, 4'd3, {88'h0, 8'h22, 8'h11}, 1'b0);
    chk("R2 load", sh_load_o, 1); chk("R2 cmd", sh_data_o, 8'h2B);
    chk("R3 cmd phase", phase_o, 2'b00); chk("R2 dir", sh_out_o, 1);
    shift(1, 0);
    chk("R2 d1", sh_data_o, 8'h11); chk("R2 ld1", sh_load_o, 1);
    chk("R3 even", phase_o, 2'b01);
    shift(1, 0);
    chk("R2 d2", sh_data_o, 8'h22); chk("R3 odd", phase_o, 2'b10);
    shift(1, 0);
    chk("R2 done", done_o, 1); chk("R2 err", err_o, 0);
    chk("R2 idle", phase_o, 2'b11);
  endtask

  task automatic t_reply;   // R4 R12
    send_req(8'h2C, 4'd1, '0, 1'b1);
    shift(1, 0);
    chk("R4 dir", sh_out_o, 0); chk("R4 phase", phase_o, 2'b01);
    chk("R12 poll", last_poll_o, 8'h2C);
    shift(1, 8'hA1);
    shift(1, 8'hB2);
    shift(0, 8'hEE);
    chk("R4 done", done_o, 1); chk("R4 len", reply_len_o, 3);
    chk("R4 b0", rb(0), 8'h2C); chk("R4 b1", rb(1), 8'hA1);
    chk("R4 b2", rb(2), 8'hB2); chk("R4 idle", phase_o, 2'b11);
  endtask

  task automatic t_timeout; // R7
    send_req(8'h2C, 4'd1, '0, 1'b1);
    shift(1, 0);
    shift(0, 8'h55);
    chk("R7 flag", timeout_o, 1);
    shift(0, 8'h66);
    shift(0, 8'h77);
    chk("R7 done", done_o, 1); chk("R7 to", timeout_o, 1);
    chk("R7 len", reply_len_o, 0);
  endtask

  task automatic t_srq;     // R8
    send_req(8'h2C, 4'd1, '0, 1'b1);
    shift(1, 0);
    shift(1, 8'hA1);
    shift(0, 8'hB2);
    chk("R8 flag", srq_o, 1); chk("R8 phase", phase_o, 2'b01);
    shift(1, 8'hC3);
    shift(0, 8'h00);
    chk("R8 done", done_o, 1); chk("R8 srq", srq_o, 1);
    chk("R8 to", timeout_o, 0); chk("R8 len", reply_len_o, 4);
    chk("R8 b2", rb(2), 8'hB2); chk("R8 b3", rb(3), 8'hC3);
  endtask

  task automatic t_autopoll; // R5
    shift(1, 8'h99);
    chk("R5 ignore pkt", pkt_o, 0); chk("R5 ignore phase", phase_o, 2'b11);
    shift(0, 8'h40);
    chk("R5 phase", phase_o, 2'b01); chk("R5 dir", sh_out_o, 0);
    shift(1, 8'h41);
    shift(1, 8'h42);
    shift(0, 8'h00);
    chk("R5 pkt", pkt_o, 1); chk("R5 len", reply_len_o, 3);
    chk("R5 b0", rb(0), 8'h40); chk("R5 b2", rb(2), 8'h42);
  endtask

  task automatic t_cap;     // R9
    shift(0, 8'h50);
    for (int i = 0; i < 20; i++) shift(1, 8'h80 + 8'(i));
    shift(0, 8'h00);
    chk("R9 pkt", pkt_o, 1); chk("R9 len", reply_len_o, 16);
    chk("R9 b15", rb(15), 8'h8E);
  endtask

  task automatic t_reject;  // R10
    send_req(8'h2B, 4'd0, '0, 1'b0);
    chk("R10 done0", done_o, 1); chk("R10 err0", err_o, 1);
    chk("R10 noload0", sh_load_o, 0); chk("R10 idle0", phase_o, 2'b11);
    @(negedge clk_i);
    send_req(8'h2B, 4'd15, '0, 1'b0);
    chk("R10 done15", done_o, 1); chk("R10 err15", err_o, 1);
    chk("R10 noload15", sh_load_o, 0);
  endtask

  task automatic t_talk;    // R11 R12
    send_req(8'h3C, 4'd1, '0, 1'b0);
    shift(1, 0);
    chk("R11 done", done_o, 1); chk("R11 err", err_o, 0);
    chk("R11 dir", sh_out_o, 0); chk("R12 poll", last_poll_o, 8'h3C);
    shift(1, 8'h91);
    shift(1, 8'h92);
    shift(0, 8'h00);
    chk("R11 pkt", pkt_o, 1); chk("R11 len", reply_len_o, 3);
    chk("R11 b0", rb(0), 8'h3C);
    send_req(8'h3D, 4'd1, '0, 1'b1);
    shift(1, 0);
    shift(1, 8'h01);
    shift(1, 8'h02);
    shift(0, 8'h00);
    chk("R12 done", done_o, 1); chk("R12 keep", last_poll_o, 8'h3C);
  endtask

  task automatic t_lost;    // R6
    send_req(8'h51, 4'd2, {96'h0, 8'h77}, 1'b0);
    shift(0, 8'hFF);
    chk("R6 phase", phase_o, 2'b01); chk("R6 dir", sh_out_o, 0);
    chk("R6 nodone", done_o, 0);
    shift(1, 8'h11);
    shift(1, 8'h22);
    shift(0, 8'h00);
    chk("R6 pkt", pkt_o, 1); chk("R6 len", reply_len_o, 3);
    chk("R6 b0", rb(0), 8'h3D);
    chk("R6 reload", sh_load_o, 1); chk("R6 recmd", sh_data_o, 8'h51);
    chk("R6 cmdph", phase_o, 2'b00);
    shift(1, 0);
    chk("R6 d1", sh_data_o, 8'h77);
    shift(1, 0);
    chk("R6 done", done_o, 1); chk("R6 idle", phase_o, 2'b11);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_write;
    t_reply;
    t_timeout;
    t_srq;
    t_autopoll;
    t_cap;
    @(negedge clk_i);
    t_reject;
    @(negedge clk_i);
    t_talk;
    t_lost;
    repeat (2) @(negedge clk_i);
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run;
  end
endmodule